// File: doc/BRIEF.md
# Packet-Driven Next Fetch Address Selector

This block sits at the tail of an instruction-packet cache and decides where the front end fetches next. Every packet stores the metadata it needs to name its own successor. That metadata is a full tag, two short next-address fields (one for fall-through, one for the predicted target), a 4-bit control token, and an index into a jump table. The block picks one of several prepared values with a single multiplexer. No adder sits in the loop from one fetch to the next, so the next address only becomes known when the current packet arrives.

The short fields replace the low bits of the current address, and the upper bits come from the packet's tag. The block owns an eight-entry call-return stack. A call token pushes the fall-through address, and a return token pops it. The stored tag is compared with the requested fetch address. On a mismatch the block raises a miss and holds the fetch address until the cache presents the refilled packet.

Top module: `pkt_next_fetch`

## Requirements
- R1: After reset, `fetch_addr` equals the RESET_ADDR parameter, `pkt_miss` is low and the call-return stack is empty.
- R2: When `pkt_valid` is high and `pkt_tag` differs from `fetch_addr`, `pkt_miss` is high in that same cycle, `fetch_addr` keeps its value at the next edge and the stack is left untouched.
- R3: Token 0 (fall-through): on a hit, the next `fetch_addr` is `{pkt_tag[47:16], pkt_seq}`.
- R4: Token 1 (predicted): on a hit, the next `fetch_addr` is `{pkt_tag[47:16], pkt_pred}`.
- R5: Token 2 (call): on a hit, the next `fetch_addr` is the predicted address, and the fall-through address `{pkt_tag[47:16], pkt_seq}` is pushed onto the stack.
- R6: Token 3 (return): on a hit with a non-empty stack, the next `fetch_addr` is the most recently pushed address, and that entry is removed.
- R7: Token 3 on an empty stack yields the fall-through address and leaves the stack empty.
- R8: Token 4 (table jump): `jt_idx` mirrors `pkt_jidx` at once, and on a hit the next `fetch_addr` equals `jt_entry`.
- R9: Token codes 5 to 15 behave as token 0 and do not change the stack.
- R10: The stack is last-in first-out with 8 entries. A ninth push without a pop discards the oldest entry, so the next eight returns give the eight newest addresses and a further return falls back to fall-through.
- R11: While `pkt_valid` is low, `fetch_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet is presented this cycle |
| pkt_tag | input | 48 | Full address stored with the packet |
| pkt_seq | input | 16 | Low bits of the fall-through successor |
| pkt_pred | input | 16 | Low bits of the predicted successor |
| pkt_token | input | 4 | Selects how the successor is formed |
| pkt_jidx | input | 4 | Jump table index carried by the packet |
| jt_idx | output | 4 | Index driven to the jump table |
| jt_entry | input | 48 | Jump table entry read at `jt_idx` |
| pkt_miss | output | 1 | Stored tag differs from the requested address |
| fetch_addr | output | 48 | Current fetch address |

## Verification
Each token is driven with distinct fall-through and predicted fields, so a wrong multiplexer leg shows up as a different low half. The jump entry carries different upper bits, which separates the table leg from the tag splice. Returns on an empty stack, and returns issued after a missed call, expose whether the stack moved when it should not. Nested calls show the last-in first-out order. Nine calls followed by nine returns separate the wrap-on-overflow behaviour from saturation and from the underflow fallback.

// File: rtl/nfa_pkg.sv
package nfa_pkg;
    localparam int FA_W   = 48;
    localparam int LOW_W  = 16;
    localparam int TOK_W  = 4;
    localparam int JIDX_W = 4;
    localparam int HI_W   = FA_W - LOW_W;

    typedef enum logic [TOK_W-1:0] {
        TK_SEQ  = 4'd0,
        TK_PRED = 4'd1,
        TK_CALL = 4'd2,
        TK_RET  = 4'd3,
        TK_JUMP = 4'd4
    } tok_e;

    typedef struct packed {
        logic [FA_W-1:0]   tag;
        logic [LOW_W-1:0]  seq;
        logic [LOW_W-1:0]  pred;
        logic [TOK_W-1:0]  tok;
        logic [JIDX_W-1:0] jidx;
    } pkt_meta_t;

    typedef struct packed {
        logic push;
        logic pop;
    } stk_op_t;

    function automatic logic [FA_W-1:0] splice_low(input logic [FA_W-1:0] base,
                                                   input logic [LOW_W-1:0] low);
        return {base[FA_W-1:LOW_W], low};
    endfunction
endpackage

// File: rtl/nfa_tag_chk.sv
module nfa_tag_chk
    import nfa_pkg::*;
(
    input  logic            valid,
    input  logic [FA_W-1:0] stored_tag,
    input  logic [FA_W-1:0] want_addr,
    output logic            hit,
    output logic            miss
);
    logic same;
    always_comb begin
        same = (stored_tag == want_addr);
        hit  = valid && same;
        miss = valid && !same;
    end
endmodule

// File: rtl/nfa_ras.sv
module nfa_ras
    import nfa_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    input  logic [FA_W-1:0] push_addr,
    output logic [FA_W-1:0] top_addr,
    output logic            empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

    logic [FA_W-1:0]  slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] top_ptr;
    logic [CNT_W-1:0] fill;

    always_comb begin
        top_ptr  = wr_ptr - PTR_W'(1);
        top_addr = slots[top_ptr];
        empty    = (fill == '0);
    end

    always_ff @(posedge clk) begin
        if (push) slots[wr_ptr] <= push_addr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            fill   <= '0;
        end else if (push) begin
            wr_ptr <= wr_ptr + PTR_W'(1);
            if (fill != FULL) fill <= fill + CNT_W'(1);
        end else if (pop && !empty) begin
            wr_ptr <= top_ptr;
            fill   <= fill - CNT_W'(1);
        end
    end

    // R10
    ras_fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fill <= FULL);

    // R10
    ras_full_stays_chk: assert property (@(posedge clk) disable iff (rst)
        (push && fill == FULL) |=> (fill == FULL));

    // R7
    ras_empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop && !push && empty) |=> (empty && $stable(wr_ptr)));
endmodule

// File: rtl/nfa_sel.sv
module nfa_sel
    import nfa_pkg::*;
(
    input  pkt_meta_t       meta,
    input  logic [FA_W-1:0] stk_top,
    input  logic            stk_empty,
    input  logic [FA_W-1:0] jt_entry,
    output logic [FA_W-1:0] next_addr,
    output logic [FA_W-1:0] fall_addr,
    output stk_op_t         op
);
    logic [FA_W-1:0] pred_addr;

    always_comb begin
        fall_addr = splice_low(meta.tag, meta.seq);
        pred_addr = splice_low(meta.tag, meta.pred);
        op        = '0;
        next_addr = fall_addr;
        case (meta.tok)
            TK_SEQ:  next_addr = fall_addr;
            TK_PRED: next_addr = pred_addr;
            TK_CALL: begin
                next_addr = pred_addr;
                op.push   = 1'b1;
            end
            TK_RET: begin
                op.pop    = 1'b1;
                next_addr = stk_empty ? fall_addr : stk_top;
            end
            TK_JUMP: next_addr = jt_entry;
            default: next_addr = fall_addr;
        endcase
    end
endmodule

// File: rtl/pkt_next_fetch.sv
module pkt_next_fetch
    import nfa_pkg::*;
#(
    parameter logic [47:0] RESET_ADDR = 48'h00AB_CDEF_0000,
    parameter int          RAS_DEPTH  = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pkt_valid,
    input  logic [47:0] pkt_tag,
    input  logic [15:0] pkt_seq,
    input  logic [15:0] pkt_pred,
    input  logic [3:0]  pkt_token,
    input  logic [3:0]  pkt_jidx,
    output logic [3:0]  jt_idx,
    input  logic [47:0] jt_entry,
    output logic        pkt_miss,
    output logic [47:0] fetch_addr
);
    pkt_meta_t       meta;
    stk_op_t         op;
    logic            hit;
    logic [FA_W-1:0] next_addr;
    logic [FA_W-1:0] fall_addr;
    logic [FA_W-1:0] stk_top;
    logic            stk_empty;

    always_comb begin
        meta.tag  = pkt_tag;
        meta.seq  = pkt_seq;
        meta.pred = pkt_pred;
        meta.tok  = pkt_token;
        meta.jidx = pkt_jidx;
        jt_idx    = meta.jidx;
    end

    nfa_tag_chk u_tag (
        .valid      (pkt_valid),
        .stored_tag (meta.tag),
        .want_addr  (fetch_addr),
        .hit        (hit),
        .miss       (pkt_miss)
    );

    nfa_sel u_sel (
        .meta      (meta),
        .stk_top   (stk_top),
        .stk_empty (stk_empty),
        .jt_entry  (jt_entry),
        .next_addr (next_addr),
        .fall_addr (fall_addr),
        .op        (op)
    );

    nfa_ras #(.DEPTH(RAS_DEPTH)) u_ras (
        .clk       (clk),
        .rst       (rst),
        .push      (hit && op.push),
        .pop       (hit && op.pop),
        .push_addr (fall_addr),
        .top_addr  (stk_top),
        .empty     (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst)      fetch_addr <= RESET_ADDR;
        else if (hit) fetch_addr <= next_addr;
    end

    // R2
    miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
        pkt_miss |=> $stable(fetch_addr));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !pkt_valid |=> $stable(fetch_addr));

    // R3
    seq_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_miss && pkt_token == 4'd0)
            |=> (fetch_addr[LOW_W-1:0] == $past(pkt_seq)));

    // R4
    pred_low_chk: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && !pkt_miss && pkt_token == 4'd1)
            |=> (fetch_addr[LOW_W-1:0] == $past(pkt_pred)));
endmodule

// File: tb/pkt_next_fetch_bench.sv
`timescale 1ns/1ps
module pkt_next_fetch_bench;
    localparam logic [47:0] RST_A = 48'h00AB_CDEF_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic        pkt_valid;
    logic [47:0] pkt_tag;
    logic [15:0] pkt_seq, pkt_pred;
    logic [3:0]  pkt_token, pkt_jidx, jt_idx;
    logic [47:0] jt_entry;
    logic        pkt_miss;
    logic [47:0] fetch_addr;

    int n_run = 0;
    int n_fail = 0;
    logic [47:0] stk [$];

    always #4 clk = ~clk;

    pkt_next_fetch u_pkt_next_fetch (
        .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_tag(pkt_tag),
        .pkt_seq(pkt_seq), .pkt_pred(pkt_pred), .pkt_token(pkt_token),
        .pkt_jidx(pkt_jidx), .jt_idx(jt_idx), .jt_entry(jt_entry),
        .pkt_miss(pkt_miss), .fetch_addr(fetch_addr)
    );

    task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One packet presentation; model computed from the requirements.
    task automatic present(input string req, input logic [3:0] tok, input logic [15:0] s,
                           input logic [15:0] p, input logic [3:0] jx,
                           input logic [47:0] jte, input bit bad);
        logic [47:0] cur, fall, pred, exp;
        @(negedge clk);
        cur  = fetch_addr;
        fall = {cur[47:16], s};
        pred = {cur[47:16], p};
        pkt_valid = 1'b1;
        pkt_tag   = bad ? (cur ^ 48'h8000_0000_0000) : cur;
        pkt_seq = s; pkt_pred = p; pkt_token = tok; pkt_jidx = jx; jt_entry = jte;
        #1;
        check({req, " miss"}, {47'd0, pkt_miss}, {47'd0, bad});
        if (tok == 4'd4) check("R8 jt_idx", {44'd0, jt_idx}, {44'd0, jx});
        if (bad) exp = cur;
        else begin
            case (tok)
                4'd1: exp = pred;
                4'd2: begin exp = pred; stk.push_back(fall); if (stk.size() > 8) void'(stk.pop_front()); end
                4'd3: exp = (stk.size() > 0) ? stk.pop_back() : fall;
                4'd4: exp = jte;
                default: exp = fall;
            endcase
        end
        @(posedge clk); #1;
        pkt_valid = 1'b0;
        check(req, fetch_addr, exp);
    endtask

    task automatic t_reset();
        check("R1 reset addr", fetch_addr, RST_A);
        check("R1 miss low", {47'd0, pkt_miss}, 48'd0);
        present("R1 R7 empty return", 4'd3, 16'h1111, 16'h2222, 4'd0, 48'd0, 1'b0);
    endtask

    task automatic t_basic();
        present("R3 seq", 4'd0, 16'h0040, 16'h9000, 4'd0, 48'd0, 1'b0);
        present("R4 pred", 4'd1, 16'h0080, 16'h7A00, 4'd0, 48'd0, 1'b0);
        present("R8 jump", 4'd4, 16'h0100, 16'h0200, 4'd9, 48'h1234_5678_9ABC, 1'b0);
        present("R3 seq after jump", 4'd0, 16'h5550, 16'hAAA0, 4'd0, 48'd0, 1'b0);
    endtask

    task automatic t_reserved();
        present("R9 code5", 4'd5, 16'h0300, 16'hF000, 4'd0, 48'd0, 1'b0);
        present("R9 code9", 4'd9, 16'h0310, 16'hF100, 4'd0, 48'd0, 1'b0);
        present("R9 code15", 4'd15, 16'h0320, 16'hF200, 4'd0, 48'd0, 1'b0);
        present("R9 R7 stack still empty", 4'd3, 16'h0330, 16'hF300, 4'd0, 48'd0, 1'b0);
    endtask

    task automatic t_miss();
        present("R2 missed call", 4'd2, 16'h0400, 16'hE000, 4'd0, 48'd0, 1'b1);
        present("R2 missed seq", 4'd0, 16'h0410, 16'hE100, 4'd0, 48'd0, 1'b1);
        present("R2 R7 no push on miss", 4'd3, 16'h0420, 16'hE200, 4'd0, 48'd0, 1'b0);
    endtask

    task automatic t_idle();
        logic [47:0] held;
        held = fetch_addr;
        repeat (3) @(posedge clk);
        #1 check("R11 idle hold", fetch_addr, held);
    endtask

    task automatic t_nest();
        present("R5 call a", 4'd2, 16'h0500, 16'hD000, 4'd0, 48'd0, 1'b0);
        present("R5 call b", 4'd2, 16'h0510, 16'hD100, 4'd0, 48'd0, 1'b0);
        present("R6 ret b", 4'd3, 16'h0520, 16'hD200, 4'd0, 48'd0, 1'b0);
        present("R6 ret a", 4'd3, 16'h0530, 16'hD300, 4'd0, 48'd0, 1'b0);
        present("R7 ret empty", 4'd3, 16'h0540, 16'hD400, 4'd0, 48'd0, 1'b0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 9; i++)
            present("R10 call", 4'd2, 16'h0600 + 16'(i * 16), 16'hC000 + 16'(i * 256),
                    4'd0, 48'd0, 1'b0);
        for (int i = 0; i < 9; i++)
            present("R10 ret", 4'd3, 16'h0700 + 16'(i * 16), 16'hB000, 4'd0, 48'd0, 1'b0);
    endtask

    initial begin
        #(8 * 20000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; pkt_valid = 1'b0; pkt_tag = '0; pkt_seq = '0; pkt_pred = '0;
        pkt_token = '0; pkt_jidx = '0; jt_entry = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        #1;
        t_reset();
        t_reserved();
        t_miss();
        t_basic();
        t_idle();
        t_nest();
        t_overflow();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule